// File: doc/BRIEF.md
# Pixel Color Matrix with Coefficient Converter

This block applies a 3×3 signed fixed-point matrix to a stream of RGB pixels with 12-bit components. Each output component is a weighted sum of the three input components. The sum is scaled back to the component range and saturated at both ends. Pixels enter with a valid flag and leave a fixed number of clock edges later with a matching valid flag.

Coefficients arrive one at a time over a load port. Each carries an index and a 64-bit sign-magnitude value with 32 fractional bits. A converter turns the value into a 15-bit two's-complement number with 12 fractional bits and decides whether it fits. Accepted values go into a staging set. A separate commit strobe copies all nine staged values into the active matrix in a single cycle, so the pixel path never sees a half-updated matrix. A rejected value raises an error flag and changes nothing.

Top module: `color_matrix`

## Requirements
- R1: A coefficient's sign is bit 63 of the loaded value. Its magnitude is bits 34:20, so bits 62:35 and 19:0 are discarded. When the sign is set, the stored 15-bit value is the two's-complement negation of the magnitude; otherwise it is the magnitude itself. The value 4096 represents 1.0.
- R2: A loaded value is rejected when its sign bit differs from bit 14 of the converted result. This rejects magnitudes of 0x4000 and above with a positive sign, and a negative sign with magnitude 0 or above 0x4000. A negative sign with magnitude 0x4000 (that is, -4.0) is accepted, and so is a negative sign with magnitude 0x2000.
- R3: A rejected write raises `coef_err` for exactly one cycle, starting right after the clock edge that samples the strobe. It leaves the staged coefficient unchanged. An accepted write never raises `coef_err`.
- R4: Writes change only the staging set. The active matrix takes all nine staged values together on a clock edge where `coef_commit` is high. When a write and a commit share an edge, the commit copies the staging contents as they were before that write.
- R5: A write with `coef_idx` of 9 or more has no effect and raises no error.
- R6: Coefficient index k sits at row k/3 and column k%3. Rows 0, 1 and 2 produce the red, green and blue outputs. Columns 0, 1 and 2 weight the red, green and blue inputs. Each output is floor(sum of the three products / 4096), clamped to the range 0 to 4095.
- R7: Each input pixel is sampled on an edge with `pix_in_vld` high. Its result is on the outputs, with `pix_out_vld` high, right after the second edge that follows. Back-to-back pixels yield back-to-back results, in order.
- R8: After reset, both the staging set and the active matrix hold the identity matrix (4096 on indices 0, 4 and 8, zero elsewhere), and `pix_out_vld` and `coef_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Coefficient index, 0 to 8 |
| coef_val | input | 64 | Sign-magnitude coefficient, 32 fractional bits |
| coef_commit | input | 1 | Copy the staging set into the active matrix |
| coef_err | output | 1 | One-cycle pulse for a rejected coefficient |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in_r | input | 12 | Input red |
| pix_in_g | input | 12 | Input green |
| pix_in_b | input | 12 | Input blue |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out_r | output | 12 | Output red |
| pix_out_g | output | 12 | Output green |
| pix_out_b | output | 12 | Output blue |

## Verification
The hardest cases to reach are the boundary values of the overflow rule: -4.0 is accepted while negative zero and +4.0 are rejected. A further case is a value whose only set bits lie above bit 34, which converts silently to zero.

A table drives each such value into index 0 over the load port. Before each entry, the table restores a baseline of 1.0 and commits it. It then commits the entry and pushes a pixel whose red output separates every outcome: an accepted value scales the pixel, while a rejected one leaves the baseline result.

Directed tests then cover the other cases that are hard to reach from the ports. One test probes the staging/active split by sending a pixel before the commit. Another puts a write and a commit on the same edge.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int CM_DIM     = 3;
  localparam int CM_COMP_W  = 12;
  localparam int CM_COEF_W  = 15;
  localparam int CM_Q_FRAC  = 12;
  localparam int CM_IN_W    = 64;
  localparam int CM_IN_FRAC = 32;
  localparam int CM_IDX_W   = 4;
endpackage

// File: rtl/cm_coef_conv.sv
module cm_coef_conv #(
  parameter int IN_W   = 64,
  parameter int IN_FRAC = 32,
  parameter int Q_W    = 15,
  parameter int Q_FRAC = 12
) (
  input  logic [IN_W-1:0] raw,
  output logic [Q_W-1:0]  q,
  output logic            ok
);
  localparam int SH = IN_FRAC - Q_FRAC;

  logic           sgn;
  logic [Q_W-1:0] mag;

  always_comb begin
    sgn = raw[IN_W-1];
    mag = raw[SH +: Q_W];
    q   = sgn ? (Q_W'(0) - mag) : mag;
    ok  = (sgn == q[Q_W-1]);
  end
endmodule

// File: rtl/cm_coef_bank.sv
module cm_coef_bank #(
  parameter int DIM  = 3,
  parameter int W    = 15,
  parameter int FRAC = 12,
  parameter int IW   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [IW-1:0]                idx,
  input  logic [W-1:0]                 wdata,
  input  logic                         wok,
  input  logic                         commit,
  output logic [DIM*DIM-1:0][W-1:0]    active,
  output logic                         err
);
  localparam int N = DIM * DIM;
  localparam logic [W-1:0] ONE = W'(1 << FRAC);

  logic [N-1:0][W-1:0] stage;
  logic                hit;

  assign hit = wr && (32'(idx) < N);

  for (genvar k = 0; k < N; k++) begin : g_coef
    localparam logic [W-1:0] INIT = ((k % (DIM + 1)) == 0) ? ONE : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        stage[k] <= INIT;
      end else if (hit && wok && (idx == IW'(k))) begin
        stage[k] <= wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active[k] <= INIT;
      end else if (commit) begin
        active[k] <= stage[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else begin
      err <= hit && !wok;
    end
  end
endmodule

// File: rtl/cm_mac_row.sv
module cm_mac_row #(
  parameter int DIM  = 3,
  parameter int CW   = 12,
  parameter int KW   = 15,
  parameter int FRAC = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DIM-1:0][KW-1:0]   coef,
  input  logic [DIM-1:0][CW-1:0]   comp,
  output logic [CW-1:0]            res
);
  localparam int PW = KW + CW + 1;
  localparam int SW = PW + $clog2(DIM) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << CW) - 1);

  logic signed [PW-1:0] cext [DIM];
  logic signed [PW-1:0] xext [DIM];
  logic signed [PW-1:0] prod [DIM];
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] sum_q;
  logic signed [SW-1:0] shifted;

  always_comb begin
    for (int j = 0; j < DIM; j++) begin
      cext[j] = PW'($signed(coef[j]));
      xext[j] = $signed(PW'({1'b0, comp[j]}));
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DIM; j++) begin
      if (rst) prod[j] <= '0;
      else     prod[j] <= cext[j] * xext[j];
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < DIM; j++) begin
      acc = acc + SW'(prod[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= acc;
  end

  assign shifted = sum_q >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
    end else if (shifted < 0) begin
      res <= '0;
    end else if (shifted > MAXV) begin
      res <= MAXV[CW-1:0];
    end else begin
      res <= shifted[CW-1:0];
    end
  end
endmodule

// File: rtl/color_matrix.sv
module color_matrix
  import cm_pkg::*;
#(
  parameter int COMP_W  = CM_COMP_W,
  parameter int COEF_W  = CM_COEF_W,
  parameter int Q_FRAC  = CM_Q_FRAC,
  parameter int IN_W    = CM_IN_W,
  parameter int IN_FRAC = CM_IN_FRAC,
  parameter int IDX_W   = CM_IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_wr,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [IN_W-1:0]   coef_val,
  input  logic              coef_commit,
  output logic              coef_err,
  input  logic              pix_in_vld,
  input  logic [COMP_W-1:0] pix_in_r,
  input  logic [COMP_W-1:0] pix_in_g,
  input  logic [COMP_W-1:0] pix_in_b,
  output logic              pix_out_vld,
  output logic [COMP_W-1:0] pix_out_r,
  output logic [COMP_W-1:0] pix_out_g,
  output logic [COMP_W-1:0] pix_out_b
);
  localparam int DIM = CM_DIM;
  localparam int N   = DIM * DIM;
  localparam int LAT = 3;

  logic [COEF_W-1:0]             conv_q;
  logic                          conv_ok;
  logic [N-1:0][COEF_W-1:0]      active;
  logic [DIM-1:0][COMP_W-1:0]    comp_in;
  logic [DIM-1:0][COMP_W-1:0]    comp_out;
  logic [LAT-1:0]                vpipe;

  cm_coef_conv #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .Q_W(COEF_W), .Q_FRAC(Q_FRAC)
  ) u_conv (
    .raw(coef_val), .q(conv_q), .ok(conv_ok)
  );

  cm_coef_bank #(
    .DIM(DIM), .W(COEF_W), .FRAC(Q_FRAC), .IW(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr(coef_wr), .idx(coef_idx),
    .wdata(conv_q), .wok(conv_ok), .commit(coef_commit),
    .active(active), .err(coef_err)
  );

  assign comp_in = {pix_in_b, pix_in_g, pix_in_r};

  for (genvar r = 0; r < DIM; r++) begin : g_row
    cm_mac_row #(
      .DIM(DIM), .CW(COMP_W), .KW(COEF_W), .FRAC(Q_FRAC)
    ) u_row (
      .clk(clk), .rst(rst),
      .coef(active[r*DIM +: DIM]),
      .comp(comp_in),
      .res(comp_out[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], pix_in_vld};
  end

  assign pix_out_vld = vpipe[LAT-1];
  assign pix_out_r   = comp_out[0];
  assign pix_out_g   = comp_out[1];
  assign pix_out_b   = comp_out[2];
endmodule

// File: rtl/cm_checker.sv
module cm_checker #(
  parameter int IN_W    = 64,
  parameter int IN_FRAC = 32,
  parameter int Q_W     = 15,
  parameter int Q_FRAC  = 12,
  parameter int IDX_W   = 4,
  parameter int NCOEF   = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             coef_wr,
  input logic [IDX_W-1:0] coef_idx,
  input logic [IN_W-1:0]  coef_val,
  input logic             coef_err,
  input logic             pix_in_vld,
  input logic             pix_out_vld
);
  localparam int SH = IN_FRAC - Q_FRAC;

  logic [1:0] since_rst;
  logic       idx_ok;

  assign idx_ok = 32'(coef_idx) < NCOEF;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R7: valid leaves three edges after it enters
  assert_vld_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (pix_out_vld == $past(pix_in_vld, 3)));

  // R3: an error pulse only follows an in-range write
  assert_err_cause_R3: assert property (@(posedge clk) disable iff (rst)
    coef_err |-> $past(coef_wr && idx_ok));

  // R2: positive magnitude reaching bit 14 is rejected
  assert_pos_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (coef_wr && idx_ok && !coef_val[IN_W-1] && coef_val[SH+Q_W-1]) |=> coef_err);

  // R2: negative zero is rejected
  assert_neg_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (coef_wr && idx_ok && coef_val[IN_W-1] && (coef_val[SH +: Q_W] == '0)) |=> coef_err);

  // R5: out-of-range index never errors
  assert_idx_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (coef_wr && !idx_ok) |=> !coef_err);
endmodule

bind color_matrix cm_checker #(
  .IN_W(IN_W), .IN_FRAC(IN_FRAC), .Q_W(COEF_W), .Q_FRAC(Q_FRAC),
  .IDX_W(IDX_W), .NCOEF(9)
) u_chk (
  .clk(clk), .rst(rst), .coef_wr(coef_wr), .coef_idx(coef_idx),
  .coef_val(coef_val), .coef_err(coef_err),
  .pix_in_vld(pix_in_vld), .pix_out_vld(pix_out_vld)
);

// File: tb/tb_color_matrix.sv
module tb_color_matrix;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coef_wr = 1'b0;
  logic [3:0]  coef_idx = '0;
  logic [63:0] coef_val = '0;
  logic        coef_commit = 1'b0;
  logic        coef_err;
  logic        pix_in_vld = 1'b0;
  logic [11:0] pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
  logic        pix_out_vld;
  logic [11:0] pix_out_r, pix_out_g, pix_out_b;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  color_matrix dut (
    .clk(clk), .rst(rst), .coef_wr(coef_wr), .coef_idx(coef_idx),
    .coef_val(coef_val), .coef_commit(coef_commit), .coef_err(coef_err),
    .pix_in_vld(pix_in_vld), .pix_in_r(pix_in_r), .pix_in_g(pix_in_g),
    .pix_in_b(pix_in_b), .pix_out_vld(pix_out_vld), .pix_out_r(pix_out_r),
    .pix_out_g(pix_out_g), .pix_out_b(pix_out_b)
  );

  typedef struct packed {
    logic [63:0] val;
    logic        err;
    logic [11:0] red;
  } vec_t;

  // red output for pixel (2048,0,0) with the entry in index 0
  localparam vec_t VECS [13] = '{
    '{64'h0000_0001_0000_0000, 1'b0, 12'd2048},  // R1 +1.0
    '{64'h0000_0000_8000_0000, 1'b0, 12'd1024},  // R1 +0.5
    '{64'h0000_0002_0000_0000, 1'b0, 12'd4095},  // R6 +2.0 clamps high
    '{64'h8000_0000_8000_0000, 1'b0, 12'd0},     // R6 -0.5 clamps low
    '{64'h8000_0002_0000_0000, 1'b0, 12'd0},     // R2 -2.0 accepted
    '{64'h0000_0004_0000_0000, 1'b1, 12'd2048},  // R2 +4.0 rejected
    '{64'h8000_0004_0000_0000, 1'b0, 12'd0},     // R2 -4.0 accepted
    '{64'h8000_0000_0000_0000, 1'b1, 12'd2048},  // R2 negative zero rejected
    '{64'h0000_0000_800F_FFFF, 1'b0, 12'd1024},  // R1 low bits truncated
    '{64'h0000_0003_FFF0_0000, 1'b0, 12'd4095},  // R2 largest positive
    '{64'h0000_0008_0000_0000, 1'b0, 12'd0},     // R1 high bits discarded
    '{64'h8000_0005_0000_0000, 1'b1, 12'd2048},  // R2 -5.0 rejected
    '{64'h0000_0000_4000_0000, 1'b0, 12'd512}    // R1 +0.25
  };

  localparam logic [63:0] P_ONE  = 64'h0000_0001_0000_0000;
  localparam logic [63:0] P_HALF = 64'h0000_0000_8000_0000;
  localparam logic [63:0] P_QTR  = 64'h0000_0000_4000_0000;
  localparam logic [63:0] N_QTR  = 64'h8000_0000_4000_0000;
  localparam logic [63:0] ZERO   = 64'h0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_coef(input logic [3:0] idx, input logic [63:0] val,
                         output logic e_now, output logic e_next);
    @(negedge clk);
    coef_wr = 1'b1; coef_idx = idx; coef_val = val;
    @(negedge clk);
    coef_wr = 1'b0;
    e_now = coef_err;
    @(negedge clk);
    e_next = coef_err;
  endtask

  task automatic commit();
    @(negedge clk);
    coef_commit = 1'b1;
    @(negedge clk);
    coef_commit = 1'b0;
  endtask

  task automatic run_pix(input logic [11:0] r, g, b,
                         output logic [11:0] orr, og, ob,
                         output logic early, output logic vld);
    @(negedge clk);
    pix_in_vld = 1'b1; pix_in_r = r; pix_in_g = g; pix_in_b = b;
    @(negedge clk);
    pix_in_vld = 1'b0;
    early = pix_out_vld;
    @(negedge clk);
    early = early | pix_out_vld;
    @(negedge clk);
    vld = pix_out_vld; orr = pix_out_r; og = pix_out_g; ob = pix_out_b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic e0, e1, early, vld;
    logic [11:0] o_r, o_g, o_b;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8 out_vld after reset", int'(pix_out_vld), 0);
    chk("R8 err after reset", int'(coef_err), 0);

    // R8 identity after reset, R7 latency
    run_pix(12'd100, 12'd200, 12'd300, o_r, o_g, o_b, early, vld);
    chk("R7 no early valid", int'(early), 0);
    chk("R7 valid on third edge", int'(vld), 1);
    chk("R8 identity red", int'(o_r), 100);
    chk("R8 identity green", int'(o_g), 200);
    chk("R8 identity blue", int'(o_b), 300);

    // table walk on index 0
    for (int i = 0; i < 13; i++) begin
      wr_coef(4'd0, P_ONE, e0, e1);
      commit();
      wr_coef(4'd0, VECS[i].val, e0, e1);
      chk($sformatf("R2 R3 err flag vec %0d", i), int'(e0), int'(VECS[i].err));
      chk($sformatf("R3 err one cycle vec %0d", i), int'(e1), 0);
      commit();
      run_pix(12'd2048, 12'd0, 12'd0, o_r, o_g, o_b, early, vld);
      chk($sformatf("R1 R6 red vec %0d", i), int'(o_r), int'(VECS[i].red));
    end

    // R7 back-to-back stream with identity row 0
    wr_coef(4'd0, P_ONE, e0, e1);
    commit();
    @(negedge clk);
    pix_in_vld = 1'b1; pix_in_r = 12'd11; pix_in_g = 12'd12; pix_in_b = 12'd13;
    @(negedge clk);
    pix_in_r = 12'd21; pix_in_g = 12'd22; pix_in_b = 12'd23;
    @(negedge clk);
    pix_in_r = 12'd31; pix_in_g = 12'd32; pix_in_b = 12'd33;
    @(negedge clk);
    pix_in_vld = 1'b0;
    chk("R7 stream vld 0", int'(pix_out_vld), 1);
    chk("R7 stream pix 0", int'(pix_out_r), 11);
    @(negedge clk);
    chk("R7 stream vld 1", int'(pix_out_vld), 1);
    chk("R7 stream pix 1", int'(pix_out_g), 22);
    @(negedge clk);
    chk("R7 stream vld 2", int'(pix_out_vld), 1);
    chk("R7 stream pix 2", int'(pix_out_b), 33);
    @(negedge clk);
    chk("R7 stream ends", int'(pix_out_vld), 0);

    // R4 staging: full matrix written, not yet committed
    wr_coef(4'd0, P_HALF, e0, e1);
    wr_coef(4'd1, P_QTR,  e0, e1);
    wr_coef(4'd2, P_QTR,  e0, e1);
    wr_coef(4'd3, P_ONE,  e0, e1);
    wr_coef(4'd4, P_ONE,  e0, e1);
    wr_coef(4'd5, P_ONE,  e0, e1);
    wr_coef(4'd6, P_QTR,  e0, e1);
    wr_coef(4'd7, ZERO,   e0, e1);
    wr_coef(4'd8, N_QTR,  e0, e1);
    run_pix(12'd1000, 12'd2000, 12'd400, o_r, o_g, o_b, early, vld);
    chk("R4 uncommitted red", int'(o_r), 1000);
    chk("R4 uncommitted green", int'(o_g), 2000);
    chk("R4 uncommitted blue", int'(o_b), 400);
    commit();
    run_pix(12'd1000, 12'd2000, 12'd400, o_r, o_g, o_b, early, vld);
    chk("R6 mix red", int'(o_r), 1100);
    chk("R6 mix green", int'(o_g), 3400);
    chk("R6 mix blue", int'(o_b), 150);

    // R5 out-of-range indices
    wr_coef(4'd9, 64'h8000_0000_0000_0000, e0, e1);
    chk("R5 idx 9 no err", int'(e0), 0);
    wr_coef(4'd15, 64'h0000_0004_0000_0000, e0, e1);
    chk("R5 idx 15 no err", int'(e0), 0);
    commit();
    run_pix(12'd1000, 12'd2000, 12'd400, o_r, o_g, o_b, early, vld);
    chk("R5 matrix unchanged red", int'(o_r), 1100);
    chk("R5 matrix unchanged green", int'(o_g), 3400);
    chk("R5 matrix unchanged blue", int'(o_b), 150);

    // R3 rejected write keeps staged value
    wr_coef(4'd4, 64'h0000_0004_0000_0000, e0, e1);
    chk("R3 reject flagged", int'(e0), 1);
    commit();
    run_pix(12'd1000, 12'd2000, 12'd400, o_r, o_g, o_b, early, vld);
    chk("R3 staging kept green", int'(o_g), 3400);

    // R4 write and commit on the same edge
    @(negedge clk);
    coef_wr = 1'b1; coef_idx = 4'd0; coef_val = P_ONE; coef_commit = 1'b1;
    @(negedge clk);
    coef_wr = 1'b0; coef_commit = 1'b0;
    run_pix(12'd1000, 12'd2000, 12'd400, o_r, o_g, o_b, early, vld);
    chk("R4 same-edge commit takes old", int'(o_r), 1100);
    commit();
    run_pix(12'd1000, 12'd2000, 12'd400, o_r, o_g, o_b, early, vld);
    chk("R4 later commit takes new", int'(o_r), 1600);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule